// File: doc/BRIEF.md
# Vectored Interrupt Controller With Fast Path

This block collects 64 level-sensitive interrupt lines and turns them into two request wires for a processor: an ordinary request and a fast request. A small 32-bit register port lets software enable or disable each line, steer each line to the fast wire, give it a 4-bit priority, and force it active from software. Each per-line field is held as a pair of 32-bit words: the low word covers lines 0 to 31 and the high word covers lines 32 to 63.

For the ordinary path the block picks the pending line with the highest priority and places its number in the upper half of a status word. Ties go to the higher line number. Software reads this word in a loop until it shows 0xFFFF, which means that nothing is left. A global level threshold can hold back ordinary requests of low priority. The fast path reports the highest-numbered pending fast line in the same way. Both request outputs are registered.

Top module: `vic_fast_ctrl`

## Requirements
- R1: After reset the level register (byte offset 0x04, bits [4:0]) reads 0x1F. The control word (0x00), the enable words, the type words, all priority words and the force words read 0. Both request outputs are low, and both vector words read 0xFFFF0000.
- R2: The enable words sit at 0x10 (high, line n at bit n-32) and 0x14 (low, line n at bit n). The type words sit at 0x18 (high) and 0x1C (low). The force words sit at 0x50 (high) and 0x54 (low). The control word sits at 0x00. Each of these reads back the value last written.
- R3: A write of a value v below 64 to 0x08 sets enable bit v. The same write to 0x0C clears enable bit v. A value of 64 or more at either offset leaves every enable bit unchanged.
- R4: Priority word x (x = 0..7) sits at byte offset 0x20 + 4*(7-x). Line 8x+k has its 4-bit priority in bits [4k+3:4k] of that word, and a larger value means a higher priority.
- R5: A line is active when its raw input or its force bit is 1 and its enable bit is 1. It is pending-ordinary when it is active, its type bit is 0, and either the level register is 0x1F or its priority is strictly greater than the level value. It is pending-fast when it is active and its type bit is 1. The pending words read at 0x58/0x5C (ordinary, high/low) and 0x60/0x64 (fast, high/low).
- R6: The ordinary vector word (0x40) holds the number of the highest-priority pending-ordinary line in bits [31:16], and the highest line number wins a tie. Its bits [15:0] hold that line's priority. With no pending-ordinary line the word reads 0xFFFF0000.
- R7: The fast vector word (0x44) holds the highest-numbered pending-fast line in bits [31:16] and 0 in bits [15:0]. With no pending-fast line it reads 0xFFFF0000.
- R8: The output norm_irq equals the OR of all pending-ordinary bits one clock earlier. The output fast_irq equals the OR of all pending-fast bits one clock earlier.
- R9: The raw line inputs read at 0x48 (lines 32-63) and 0x4C (lines 0-31) without delay.
- R10: A force bit makes its line active while the raw input is low. Clearing an enable bit removes the line from both pending sets at once, and this acknowledges the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 7 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_src | input | 64 | Raw level interrupt lines |
| norm_irq | output | 1 | Registered ordinary request |
| fast_irq | output | 1 | Registered fast request |

## Verification
The bench uses the default parameters: 64 lines and 4-bit priorities. With these, both halves of every paired word, all eight priority words and all sixteen priority values are in use. Every level value from 0 to 15, plus the bypass code, can be applied against real priorities. Directed ties between a low-half line and a high-half line check the line-number tie-break. Random enable, type, force and priority patterns then drive the arbiter through the whole 64-line range.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int SRC_COUNT   = 64;
    localparam int PRIO_W      = 4;
    localparam int WORD_W      = 32;
    localparam int LVL_W       = 5;
    localparam int ID_W        = $clog2(SRC_COUNT);
    localparam int FIELDS_PER  = WORD_W / PRIO_W;
    localparam logic [LVL_W-1:0] LVL_BYPASS = 5'h1F;
    localparam logic [15:0]      VEC_NONE   = 16'hFFFF;

    // word index = byte address [6:2]
    typedef enum logic [4:0] {
        IX_CTRL  = 5'd0,
        IX_LVL   = 5'd1,
        IX_ENNUM = 5'd2,
        IX_DSNUM = 5'd3,
        IX_ENH   = 5'd4,
        IX_ENL   = 5'd5,
        IX_TYH   = 5'd6,
        IX_TYL   = 5'd7,
        IX_NVEC  = 5'd16,
        IX_FVEC  = 5'd17,
        IX_SRCH  = 5'd18,
        IX_SRCL  = 5'd19,
        IX_FRH   = 5'd20,
        IX_FRL   = 5'd21,
        IX_NPH   = 5'd22,
        IX_NPL   = 5'd23,
        IX_FPH   = 5'd24,
        IX_FPL   = 5'd25
    } word_ix_e;

    typedef struct packed {
        logic [WORD_W-1:0]                 ctrl;
        logic [LVL_W-1:0]                  lvl;
        logic [SRC_COUNT-1:0]              en;
        logic [SRC_COUNT-1:0]              typ;
        logic [SRC_COUNT-1:0]              frc;
        logic [SRC_COUNT-1:0][PRIO_W-1:0]  prio;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        ctrl: '0,
        lvl:  LVL_BYPASS,
        en:   '0,
        typ:  '0,
        frc:  '0,
        prio: '0
    };

    typedef struct packed {
        logic nreq;
        logic freq;
    } req_t;

endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NSRC = SRC_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_ix,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg_q
);

    localparam int HALF = NSRC / 2;

    cfg_t       cfg_d;
    logic [2:0] pword;

    always_comb begin
        cfg_d = cfg_q;
        pword = 3'd7 - wr_ix[2:0];
        if (wr_en) begin
            if (wr_ix[4:3] == 2'b01) begin
                for (int k = 0; k < FIELDS_PER; k++) begin
                    cfg_d.prio[{pword, 3'(k)}] = wdata[PRIO_W*k +: PRIO_W];
                end
            end else begin
                case (wr_ix)
                    IX_CTRL:  cfg_d.ctrl = wdata;
                    IX_LVL:   cfg_d.lvl  = wdata[LVL_W-1:0];
                    IX_ENNUM: if (wdata < NSRC) cfg_d.en[wdata[ID_W-1:0]] = 1'b1;
                    IX_DSNUM: if (wdata < NSRC) cfg_d.en[wdata[ID_W-1:0]] = 1'b0;
                    IX_ENH:   cfg_d.en[NSRC-1:HALF]  = wdata;
                    IX_ENL:   cfg_d.en[HALF-1:0]     = wdata;
                    IX_TYH:   cfg_d.typ[NSRC-1:HALF] = wdata;
                    IX_TYL:   cfg_d.typ[HALF-1:0]    = wdata;
                    IX_FRH:   cfg_d.frc[NSRC-1:HALF] = wdata;
                    IX_FRL:   cfg_d.frc[HALF-1:0]    = wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/vic_pend_arb.sv
module vic_pend_arb
    import vic_pkg::*;
#(
    parameter int NSRC = SRC_COUNT
) (
    input  cfg_t              cfg,
    input  logic [NSRC-1:0]   src,
    output logic [NSRC-1:0]   npend,
    output logic [NSRC-1:0]   fpend,
    output logic [WORD_W-1:0] nvec_word,
    output logic [WORD_W-1:0] fvec_word
);

    localparam int PAD_ID = 16 - ID_W;
    localparam int PAD_PR = 16 - PRIO_W;

    logic              bypass;
    logic              nfound, ffound;
    logic [ID_W-1:0]   nid, fid;
    logic [PRIO_W-1:0] nprio;

    assign bypass = (cfg.lvl == LVL_BYPASS);

    // one pending cell per line
    for (genvar g = 0; g < NSRC; g++) begin : g_line
        logic active;
        logic above;
        assign active   = (src[g] | cfg.frc[g]) & cfg.en[g];
        assign above    = bypass || ({1'b0, cfg.prio[g]} > cfg.lvl);
        assign npend[g] = active & ~cfg.typ[g] & above;
        assign fpend[g] = active &  cfg.typ[g];
    end

    // highest priority, ties to the higher line number
    always_comb begin
        nfound = 1'b0;
        nid    = '0;
        nprio  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (npend[i] && (!nfound || cfg.prio[i] >= nprio)) begin
                nfound = 1'b1;
                nid    = ID_W'(i);
                nprio  = cfg.prio[i];
            end
        end
    end

    always_comb begin
        ffound = 1'b0;
        fid    = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (fpend[i]) begin
                ffound = 1'b1;
                fid    = ID_W'(i);
            end
        end
    end

    always_comb begin
        nvec_word = nfound ? {{PAD_ID{1'b0}}, nid, {PAD_PR{1'b0}}, nprio}
                           : {VEC_NONE, 16'h0000};
        fvec_word = ffound ? {{PAD_ID{1'b0}}, fid, 16'h0000}
                           : {VEC_NONE, 16'h0000};
    end

endmodule

// File: rtl/vic_rdmux.sv
module vic_rdmux
    import vic_pkg::*;
#(
    parameter int NSRC = SRC_COUNT
) (
    input  logic [4:0]        rd_ix,
    input  cfg_t              cfg,
    input  logic [NSRC-1:0]   src,
    input  logic [NSRC-1:0]   npend,
    input  logic [NSRC-1:0]   fpend,
    input  logic [WORD_W-1:0] nvec_word,
    input  logic [WORD_W-1:0] fvec_word,
    output logic [WORD_W-1:0] rdata
);

    localparam int HALF = NSRC / 2;

    logic [2:0] pword;

    always_comb begin
        rdata = '0;
        pword = 3'd7 - rd_ix[2:0];
        if (rd_ix[4:3] == 2'b01) begin
            for (int k = 0; k < FIELDS_PER; k++) begin
                rdata[PRIO_W*k +: PRIO_W] = cfg.prio[{pword, 3'(k)}];
            end
        end else begin
            case (rd_ix)
                IX_CTRL: rdata = cfg.ctrl;
                IX_LVL:  rdata = {{(WORD_W-LVL_W){1'b0}}, cfg.lvl};
                IX_ENH:  rdata = cfg.en[NSRC-1:HALF];
                IX_ENL:  rdata = cfg.en[HALF-1:0];
                IX_TYH:  rdata = cfg.typ[NSRC-1:HALF];
                IX_TYL:  rdata = cfg.typ[HALF-1:0];
                IX_NVEC: rdata = nvec_word;
                IX_FVEC: rdata = fvec_word;
                IX_SRCH: rdata = src[NSRC-1:HALF];
                IX_SRCL: rdata = src[HALF-1:0];
                IX_FRH:  rdata = cfg.frc[NSRC-1:HALF];
                IX_FRL:  rdata = cfg.frc[HALF-1:0];
                IX_NPH:  rdata = npend[NSRC-1:HALF];
                IX_NPL:  rdata = npend[HALF-1:0];
                IX_FPH:  rdata = fpend[NSRC-1:HALF];
                IX_FPL:  rdata = fpend[HALF-1:0];
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/vic_fast_ctrl.sv
module vic_fast_ctrl
    import vic_pkg::*;
#(
    parameter int NSRC   = SRC_COUNT,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   irq_src,
    output logic              norm_irq,
    output logic              fast_irq
);

    cfg_t              cfg_q;
    logic [NSRC-1:0]   npend, fpend;
    logic [WORD_W-1:0] nvec_word, fvec_word;
    logic [4:0]        word_ix;
    req_t              req_d, req_q;

    assign word_ix = bus_addr[6:2];

    vic_regs #(.NSRC(NSRC)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .wr_ix (word_ix),
        .wdata (bus_wdata),
        .cfg_q (cfg_q)
    );

    vic_pend_arb #(.NSRC(NSRC)) i_arb (
        .cfg       (cfg_q),
        .src       (irq_src),
        .npend     (npend),
        .fpend     (fpend),
        .nvec_word (nvec_word),
        .fvec_word (fvec_word)
    );

    vic_rdmux #(.NSRC(NSRC)) i_rdmux (
        .rd_ix     (word_ix),
        .cfg       (cfg_q),
        .src       (irq_src),
        .npend     (npend),
        .fpend     (fpend),
        .nvec_word (nvec_word),
        .fvec_word (fvec_word),
        .rdata     (bus_rdata)
    );

    always_comb begin
        req_d      = req_q;
        req_d.nreq = |npend;
        req_d.freq = |fpend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign norm_irq = req_q.nreq;
    assign fast_irq = req_q.freq;

endmodule

// File: rtl/vic_fast_ctrl_chk.sv
module vic_fast_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        norm_irq,
    input logic        fast_irq,
    input logic [63:0] npend,
    input logic [63:0] fpend,
    input logic [63:0] en,
    input logic [63:0] typ,
    input logic [31:0] nvec_word,
    input logic [31:0] fvec_word
);

    assert_norm_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (norm_irq == $past(|npend)));

    assert_fast_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (fast_irq == $past(|fpend)));

    assert_pend_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((npend | fpend) & ~en) == 64'd0);

    assert_pend_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((npend & typ) | (fpend & ~typ)) == 64'd0);

    assert_nvec_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (npend == 64'd0) |-> (nvec_word == 32'hFFFF0000));

    assert_nvec_member_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (npend != 64'd0) |-> (nvec_word[31:22] == 10'd0 && npend[nvec_word[21:16]]));

    assert_fvec_member_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fpend != 64'd0) |-> (fvec_word[31:22] == 10'd0 && fpend[fvec_word[21:16]]
                              && fvec_word[15:0] == 16'd0));

endmodule

bind vic_fast_ctrl vic_fast_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .norm_irq  (norm_irq),
    .fast_irq  (fast_irq),
    .npend     (npend),
    .fpend     (fpend),
    .en        (cfg_q.en),
    .typ       (cfg_q.typ),
    .nvec_word (nvec_word),
    .fvec_word (fvec_word)
);

// File: tb/test_vic_fast_ctrl.sv
module test_vic_fast_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        norm_irq, fast_irq;

    int n_chk = 0;
    int n_bad = 0;

    // spec-level mirror of the programmable state
    bit [31:0] m_ctrl;
    bit [4:0]  m_lvl;
    bit [63:0] m_en, m_typ, m_frc;
    bit [3:0]  m_prio [64];

    always #4 clk = ~clk;

    vic_fast_ctrl i_vic_fast_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_src   (irq_src),
        .norm_irq  (norm_irq),
        .fast_irq  (fast_irq)
    );

    task automatic chk(input string req, input [31:0] act, input [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit [63:0] e_active();
        return (irq_src | m_frc) & m_en;
    endfunction

    function automatic bit [63:0] e_npend();
        bit [63:0] r = '0;
        bit [63:0] a = e_active();
        for (int i = 0; i < 64; i++)
            r[i] = a[i] && !m_typ[i] && (m_lvl == 5'h1F || {1'b0, m_prio[i]} > m_lvl);
        return r;
    endfunction

    function automatic bit [63:0] e_fpend();
        return e_active() & m_typ;
    endfunction

    function automatic bit [31:0] e_nvec();
        bit [63:0] p = e_npend();
        int best = -1;
        for (int i = 0; i < 64; i++)
            if (p[i] && (best < 0 || m_prio[i] >= m_prio[best])) best = i;
        if (best < 0) return 32'hFFFF0000;
        return {16'(best), 12'd0, m_prio[best]};
    endfunction

    function automatic bit [31:0] e_fvec();
        bit [63:0] p = e_fpend();
        for (int i = 63; i >= 0; i--)
            if (p[i]) return {16'(i), 16'd0};
        return 32'hFFFF0000;
    endfunction

    function automatic bit [31:0] e_pword(input int x);
        bit [31:0] w = '0;
        for (int k = 0; k < 8; k++) w[4*k +: 4] = m_prio[8*x + k];
        return w;
    endfunction

    task automatic bw(input bit [6:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            7'h00: m_ctrl = d;
            7'h04: m_lvl = d[4:0];
            7'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
            7'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
            7'h10: m_en[63:32] = d;
            7'h14: m_en[31:0] = d;
            7'h18: m_typ[63:32] = d;
            7'h1C: m_typ[31:0] = d;
            7'h50: m_frc[63:32] = d;
            7'h54: m_frc[31:0] = d;
            default: if (a >= 7'h20 && a <= 7'h3C) begin
                for (int k = 0; k < 8; k++)
                    m_prio[8*(7 - (a - 7'h20) / 4) + k] = d[4*k +: 4];
            end
        endcase
    endtask

    task automatic br(input bit [6:0] a, output bit [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_rd(input string req, input bit [6:0] a, input bit [31:0] exp);
        bit [31:0] d;
        br(a, d);
        chk(req, d, exp);
    endtask

    task automatic set_src(input bit [63:0] v);
        @(negedge clk);
        irq_src = v;
    endtask

    // full view compare, then the registered requests one clock later
    task automatic chk_all();
        bit [63:0] np = e_npend();
        bit [63:0] fp = e_fpend();
        chk_rd("R2", 7'h10, m_en[63:32]);
        chk_rd("R2", 7'h14, m_en[31:0]);
        chk_rd("R2", 7'h1C, m_typ[31:0]);
        chk_rd("R10", 7'h50, m_frc[63:32]);
        chk_rd("R5", 7'h58, np[63:32]);
        chk_rd("R5", 7'h5C, np[31:0]);
        chk_rd("R5", 7'h60, fp[63:32]);
        chk_rd("R5", 7'h64, fp[31:0]);
        chk_rd("R6", 7'h40, e_nvec());
        chk_rd("R7", 7'h44, e_fvec());
        chk_rd("R9", 7'h4C, irq_src[31:0]);
        @(negedge clk);
        #1;
        chk("R8", {31'd0, norm_irq}, {31'd0, |np});
        chk("R8", {31'd0, fast_irq}, {31'd0, |fp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit [31:0] d;
        m_ctrl = '0; m_lvl = 5'h1F; m_en = '0; m_typ = '0; m_frc = '0;
        for (int i = 0; i < 64; i++) m_prio[i] = '0;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk_rd("R1", 7'h04, 32'h0000001F);
        chk_rd("R1", 7'h00, 32'h0);
        chk_rd("R1", 7'h14, 32'h0);
        chk_rd("R1", 7'h18, 32'h0);
        chk_rd("R1", 7'h3C, 32'h0);
        chk_rd("R1", 7'h20, 32'h0);
        chk_rd("R1", 7'h54, 32'h0);
        chk_rd("R1", 7'h40, 32'hFFFF0000);
        chk_rd("R1", 7'h44, 32'hFFFF0000);
        chk("R1", {31'd0, norm_irq}, 32'd0);
        chk("R1", {31'd0, fast_irq}, 32'd0);

        // R9 raw view, nothing enabled yet
        set_src(64'hA5A5_0F0F_1234_8001);
        #1;
        chk_rd("R9", 7'h48, 32'hA5A50F0F);
        chk_rd("R9", 7'h4C, 32'h12348001);
        chk_all();

        // R2 control readback and paired words
        bw(7'h00, 32'hCAFE0001);
        chk_rd("R2", 7'h00, 32'hCAFE0001);
        bw(7'h14, 32'h0000_0020);
        bw(7'h10, 32'h0000_0100);
        chk_rd("R2", 7'h14, 32'h00000020);
        chk_rd("R2", 7'h10, 32'h00000100);

        // R3 by-number access and the ignored range
        bw(7'h08, 32'd64);
        chk_rd("R3", 7'h14, 32'h00000020);
        chk_rd("R3", 7'h10, 32'h00000100);
        bw(7'h08, 32'd7);
        chk_rd("R3", 7'h14, 32'h000000A0);
        bw(7'h0C, 32'd200);
        chk_rd("R3", 7'h14, 32'h000000A0);
        bw(7'h0C, 32'd7);
        chk_rd("R3", 7'h14, 32'h00000020);
        bw(7'h08, 32'd63);
        chk_rd("R3", 7'h10, 32'h80000100);
        bw(7'h0C, 32'd63);
        chk_rd("R3", 7'h10, 32'h00000100);

        // R4 placement: line 5 in word 0 (0x3C), line 40 in word 5 (0x28)
        bw(7'h3C, 32'h0090_0000);
        bw(7'h28, 32'h0000_0009);
        chk_rd("R4", 7'h3C, 32'h00900000);
        chk_rd("R4", 7'h28, 32'h00000009);
        chk_rd("R4", 7'h24, 32'h0);

        // R6 tie between line 5 and line 40 at priority 9
        set_src(64'h0000_0100_0000_0020);
        #1;
        chk_rd("R6", 7'h40, {16'd40, 16'd9});
        chk_all();

        // R5 level threshold: 9 blocks priority 9, 8 lets it through
        bw(7'h04, 32'd9);
        chk_rd("R5", 7'h40, 32'hFFFF0000);
        chk_all();
        bw(7'h04, 32'd8);
        chk_rd("R5", 7'h40, {16'd40, 16'd9});
        bw(7'h04, 32'h1F);

        // R7 steer line 40 to the fast path
        bw(7'h18, 32'h0000_0100);
        chk_rd("R7", 7'h44, {16'd40, 16'd0});
        chk_rd("R6", 7'h40, {16'd5, 16'd9});
        chk_all();

        // R10 force with the raw lines low, then enable clear acknowledges
        set_src(64'd0);
        bw(7'h54, 32'h0000_0020);
        chk_rd("R10", 7'h40, {16'd5, 16'd9});
        chk_all();
        bw(7'h0C, 32'd5);
        chk_rd("R10", 7'h5C, 32'h0);
        chk_all();

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            case (op)
                0: bw(7'h10, $urandom() & $urandom());
                1: bw(7'h14, $urandom() & $urandom());
                2: bw(7'h18, $urandom() & $urandom() & $urandom());
                3: bw(7'h1C, $urandom() & $urandom() & $urandom());
                4: bw(7'h20 + 7'(4 * $urandom_range(0, 7)), $urandom());
                5: bw(7'h50 + 7'(4 * $urandom_range(0, 1)), $urandom() & $urandom() & $urandom());
                6: bw(($urandom_range(0, 1) != 0) ? 7'h08 : 7'h0C, $urandom_range(0, 80));
                7: bw(7'h04, ($urandom_range(0, 2) == 0) ? 32'($urandom_range(0, 15)) : 32'h1F);
                default: set_src({$urandom(), $urandom()});
            endcase
            #1;
            chk_all();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule